// File: doc/BRIEF.md
# Flat Page Table Walker

This unit turns a virtual address into a page table entry by reading one word from a single-level page table kept in physical memory. A table base register is loaded through a configuration write. A lookup request carries the full virtual address. The upper bits, called the virtual page number, select an entry at `base + vpn*4`. The low 12 bits are the offset within a 4 KB page and are carried through to the result unchanged. The walker issues one read on a valid/ready memory request port and waits for the response word. Then it pulses either `done`, with the entry and the physical address, or `fault` when the entry's present bit is clear.

The same request port also accepts an update operation. An update writes a caller-supplied entry back to the slot of the given page, with the referenced and dirty bits forced to one. This lets the requester record use and modification after a successful access, and then retry that access with the returned entry.

Top module: `pt_walker`

## Requirements
- R1: While reset is held, `req_ready` is 1 and `done`, `fault` and `mem_req_valid` are 0.
- R2: The memory address of a walk is the base register plus the virtual page number (`req_vaddr[31:12]`) multiplied by 4.
- R3: A base write (`cfg_base_we`) takes effect only while `req_ready` is 1. A base write made while a walk is in flight is ignored, and later walks still use the old base.
- R4: Only one memory request is outstanding at a time. Once `mem_req_valid` rises, it stays high with a stable address until `mem_req_ready` is seen, and each operation makes exactly one memory handshake.
- R5: `req_ready` falls in the cycle after a request is accepted and stays low until the `done` or `fault` pulse. Requests presented while it is low are ignored.
- R6: For a read whose entry has bit 0 (present) set, `done` pulses. During that pulse, `out_pte` equals the entry read from memory.
- R7: For a read whose entry has bit 0 clear, `fault` pulses and `done` does not. `out_pte` and `out_paddr` stay zero.
- R8: `done` and `fault` are never high together, and each is high for exactly one cycle per operation.
- R9: An update (`req_upd`=1) makes a memory write at the address given by R2. The write data is `req_wdata` with bit 1 (referenced) and bit 2 (dirty) set. The update ends with `done` whatever the present bit is, and `out_pte` shows the written word.
- R10: The walker waits any number of cycles with `mem_req_ready` low, and completes correctly once the port accepts.
- R11: On `done`, `out_paddr` equals the entry's bits 31:12 followed by `req_vaddr[11:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_we | input | 1 | Load the table base register |
| cfg_base_wdata | input | 32 | New table base physical address |
| req_valid | input | 1 | Lookup or update request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address (page number and offset) |
| req_upd | input | 1 | 1 = write back entry, 0 = lookup |
| req_wdata | input | 32 | Entry to write for an update |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | Memory request is a write |
| mem_req_addr | output | 32 | Entry physical address |
| mem_req_wdata | output | 32 | Write data for the entry |
| mem_rsp_valid | input | 1 | Memory response or write acknowledge |
| mem_rsp_rdata | input | 32 | Entry read from memory |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle page fault pulse |
| out_pte | output | 32 | Entry, valid during `done` |
| out_paddr | output | 32 | Translated physical address, valid during `done` |

## Verification
The in-line assertions check four things on every cycle. They check the handshake discipline: `req_ready` drops after acceptance and returns after the end pulse, and a stalled memory request holds its address. They also check that `done` and `fault` are exclusive single-cycle pulses. Only the directed scenarios can show the data-dependent results. These are the entry address formed from the base and page number, the split between a present and a not-present entry, the offset passthrough, the marked write data of an update, and the base register ignoring writes during a walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PG_OFF_W    = 12;
  localparam int PTE_W       = 32;
  localparam int PTE_PRESENT = 0;
  localparam int PTE_REF     = 1;
  localparam int PTE_DIRTY   = 2;
  localparam int PTE_WRITE   = 3;

  typedef enum logic [2:0] {
    W_IDLE, W_ISSUE, W_WAIT, W_DONE, W_FAULT
  } walk_state_e;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int VPN_W = 20,
  parameter int PA_W  = 32
) (
  input  logic [PA_W-1:0]  base,
  input  logic [VPN_W-1:0] vpn,
  output logic [PA_W-1:0]  addr
);
  localparam int SHIFT = $clog2(ptw_pkg::PTE_W / 8);

  logic [PA_W-1:0] scaled;

  always_comb begin
    scaled = '0;
    scaled[VPN_W+SHIFT-1:SHIFT] = vpn;
    addr = base + scaled;
  end
endmodule

// File: rtl/pt_entry_fields.sv
module pt_entry_fields
  import ptw_pkg::*;
(
  input  logic [PTE_W-1:0]          pte,
  output logic                      present,
  output logic [PTE_W-PG_OFF_W-1:0] ppn,
  output logic [PTE_W-1:0]          marked
);
  always_comb begin
    present = pte[PTE_PRESENT];
    ppn     = pte[PTE_W-1:PG_OFF_W];
    marked  = pte;
    marked[PTE_REF]   = 1'b1;
    marked[PTE_DIRTY] = 1'b1;
  end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import ptw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic upd,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  input  logic rsp_present,
  output logic req_ready,
  output logic accept,
  output logic mem_req_valid,
  output logic capture,
  output logic done,
  output logic fault
);
  walk_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      W_IDLE:  if (req_valid) state_d = W_ISSUE;
      W_ISSUE: if (mem_req_ready) state_d = W_WAIT;
      W_WAIT:  if (mem_rsp_valid) begin
                 if (upd || rsp_present) state_d = W_DONE;
                 else                    state_d = W_FAULT;
               end
      W_DONE:  state_d = W_IDLE;
      W_FAULT: state_d = W_IDLE;
      default: state_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= W_IDLE;
    else        state_q <= state_d;
  end

  assign req_ready     = (state_q == W_IDLE);
  assign accept        = req_ready && req_valid;
  assign mem_req_valid = (state_q == W_ISSUE);
  assign capture       = (state_q == W_WAIT) && mem_rsp_valid && !upd && rsp_present;
  assign done          = (state_q == W_DONE);
  assign fault         = (state_q == W_FAULT);

  a_r5_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  a_r5_ready_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> req_ready);
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_base_we,
  input  logic [PA_W-1:0]  cfg_base_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_upd,
  input  logic [PTE_W-1:0] req_wdata,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_we,
  output logic [PA_W-1:0]  mem_req_addr,
  output logic [PTE_W-1:0] mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_rdata,
  output logic             done,
  output logic             fault,
  output logic [PTE_W-1:0] out_pte,
  output logic [PTE_W-1:0] out_paddr
);
  localparam int VPN_W = VA_W - PG_OFF_W;
  localparam int PPN_W = PTE_W - PG_OFF_W;

  logic             rs_meta, rst_n_int;
  logic [PA_W-1:0]  base_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PG_OFF_W-1:0] off_q;
  logic             upd_q;
  logic [PTE_W-1:0] wdata_q, pte_q;
  logic             accept, capture, rsp_present;
  logic             base_en;
  logic [PPN_W-1:0] rsp_ppn, res_ppn, wr_ppn;
  logic [PTE_W-1:0] rsp_marked, wr_marked;
  logic             wr_present;

  // reset asserted asynchronously, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta   <= 1'b0;
      rst_n_int <= 1'b0;
    end else begin
      rs_meta   <= 1'b1;
      rst_n_int <= rs_meta;
    end
  end

  assign base_en = cfg_base_we && req_ready;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)   base_q <= '0;
    else if (base_en) base_q <= cfg_base_wdata;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      vpn_q   <= '0;
      off_q   <= '0;
      upd_q   <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      vpn_q   <= req_vaddr[VA_W-1:PG_OFF_W];
      off_q   <= req_vaddr[PG_OFF_W-1:0];
      upd_q   <= req_upd;
      wdata_q <= wr_marked;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)   pte_q <= '0;
    else if (accept)  pte_q <= wr_marked;
    else if (capture) pte_q <= mem_rsp_rdata;
  end

  pt_entry_fields u_wr_fields (
    .pte     (req_wdata),
    .present (wr_present),
    .ppn     (wr_ppn),
    .marked  (wr_marked)
  );

  pt_entry_fields u_rsp_fields (
    .pte     (mem_rsp_rdata),
    .present (rsp_present),
    .ppn     (rsp_ppn),
    .marked  (rsp_marked)
  );

  pt_addr_gen #(.VPN_W(VPN_W), .PA_W(PA_W)) u_addr (
    .base (base_q),
    .vpn  (vpn_q),
    .addr (mem_req_addr)
  );

  pt_walk_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .req_valid     (req_valid),
    .upd           (upd_q),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_present   (rsp_present),
    .req_ready     (req_ready),
    .accept        (accept),
    .mem_req_valid (mem_req_valid),
    .capture       (capture),
    .done          (done),
    .fault         (fault)
  );

  assign mem_req_we    = upd_q;
  assign mem_req_wdata = wdata_q;
  assign res_ppn       = pte_q[PTE_W-1:PG_OFF_W];
  assign out_pte       = done ? pte_q : '0;
  assign out_paddr     = done ? {res_ppn, off_q} : '0;

  a_r4_hold_issue: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  a_r7_no_done_on_fault: assert property (@(posedge clk) disable iff (!rst_n_int)
    fault |-> (out_pte == '0 && !done));
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  localparam logic [31:0] BASE_A = 32'h0001_0000;
  localparam logic [31:0] BASE_B = 32'h0002_0000;

  logic        clk, rst_n;
  logic        cfg_base_we;
  logic [31:0] cfg_base_wdata;
  logic        req_valid, req_ready, req_upd;
  logic [31:0] req_vaddr, req_wdata;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_rdata;
  logic        done, fault;
  logic [31:0] out_pte, out_paddr;

  logic [31:0] mem [0:63];
  logic [31:0] last_addr, last_wdata;
  logic        last_we;
  int          hs_cnt;
  int          checks, fails;
  bit          finished;
  logic        g_done, g_fault;
  logic [31:0] g_pte, g_pa;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n),
    .cfg_base_we(cfg_base_we), .cfg_base_wdata(cfg_base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_upd(req_upd), .req_wdata(req_wdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .done(done), .fault(fault),
    .out_pte(out_pte), .out_paddr(out_paddr)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // memory model: response one cycle after the handshake
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      hs_cnt     <= hs_cnt + 1;
      last_addr  <= mem_req_addr;
      last_we    <= mem_req_we;
      last_wdata <= mem_req_wdata;
      if (mem_req_we) mem[mem_req_addr[7:2]] <= mem_req_wdata;
      mem_rsp_rdata <= mem[mem_req_addr[7:2]];
      mem_rsp_valid <= 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // one operation; stall = cycles mem_req_ready is held low;
  // busy_base = write BASE_B while busy (must be ignored, R3)
  task automatic run_op(input logic [31:0] va, input logic upd, input logic [31:0] wd,
                        input int stall, input bit busy_base);
    int n;
    int hs0;
    logic [31:0] a0;
    hs0 = hs_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_upd = upd; req_wdata = wd;
    mem_req_ready = (stall == 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R5 busy after accept", {31'b0, req_ready}, 32'h0);
    if (busy_base) begin
      cfg_base_we = 1'b1; cfg_base_wdata = BASE_B;
    end
    if (stall > 0) begin
      a0 = mem_req_addr;
      for (int i = 0; i < stall; i++) begin
        req_valid = 1'b1; req_vaddr = 32'h0003_F000; req_upd = 1'b0;
        @(negedge clk);
        cfg_base_we = 1'b0;
        chk(mem_req_valid && mem_req_addr == a0, "R4 hold while stalled", mem_req_addr, a0);
        chk(req_ready == 1'b0, "R5 ready low while busy", {31'b0, req_ready}, 32'h0);
      end
      req_valid = 1'b0;
      mem_req_ready = 1'b1;
    end
    n = 0;
    while (!(done || fault) && n < 40) begin
      @(negedge clk);
      cfg_base_we = 1'b0;
      n++;
    end
    g_done = done; g_fault = fault; g_pte = out_pte; g_pa = out_paddr;
    chk(!(done && fault), "R8 exclusive", {30'b0, done, fault}, 32'h0);
    @(negedge clk);
    chk(!done && !fault, "R8 single-cycle pulse", {30'b0, done, fault}, 32'h0);
    chk(req_ready == 1'b1, "R5 ready after end", {31'b0, req_ready}, 32'h1);
    chk(hs_cnt == hs0 + 1, "R4 one handshake per op", hs_cnt - hs0, 32'h1);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 ready in reset", {31'b0, req_ready}, 32'h1);
    chk(!done && !fault && !mem_req_valid, "R1 outputs idle in reset",
        {29'b0, done, fault, mem_req_valid}, 32'h0);
  endtask

  task automatic t_present();
    mem[5] = 32'h0ABC_D00B;
    run_op(32'h0000_5123, 1'b0, 32'h0, 0, 1'b0);
    chk(last_addr == BASE_A + 32'd20, "R2 entry address", last_addr, BASE_A + 32'd20);
    chk(g_done && !g_fault, "R6 done for present entry", {30'b0, g_done, g_fault}, 32'h2);
    chk(g_pte == 32'h0ABC_D00B, "R6 entry returned", g_pte, 32'h0ABC_D00B);
    chk(g_pa == 32'h0ABC_D123, "R11 offset passthrough", g_pa, 32'h0ABC_D123);
  endtask

  task automatic t_fault();
    mem[9] = 32'h1234_5006;
    run_op(32'h0000_9FFF, 1'b0, 32'h0, 0, 1'b0);
    chk(g_fault && !g_done, "R7 fault for absent entry", {30'b0, g_done, g_fault}, 32'h1);
    chk(g_pte == 32'h0 && g_pa == 32'h0, "R7 no translation on fault", g_pte | g_pa, 32'h0);
  endtask

  task automatic t_stall();
    mem[17] = 32'hFFFF_F003;
    run_op(32'h0001_1ABC, 1'b0, 32'h0, 5, 1'b0);
    chk(last_addr == BASE_A + 32'd68, "R10 R2 address after stall", last_addr, BASE_A + 32'd68);
    chk(g_done && g_pa == 32'hFFFF_FABC, "R10 R11 stalled walk result", g_pa, 32'hFFFF_FABC);
  endtask

  task automatic t_base();
    mem[3] = 32'h0000_7001;
    run_op(32'h0000_3000, 1'b0, 32'h0, 0, 1'b1);
    chk(last_addr == BASE_A + 32'd12, "R3 base write during walk", last_addr, BASE_A + 32'd12);
    mem[4] = 32'h0000_8001;
    run_op(32'h0000_4000, 1'b0, 32'h0, 0, 1'b0);
    chk(last_addr == BASE_A + 32'd16, "R3 busy base write ignored", last_addr, BASE_A + 32'd16);
    @(negedge clk); cfg_base_we = 1'b1; cfg_base_wdata = BASE_B;
    @(negedge clk); cfg_base_we = 1'b0;
    run_op(32'h0000_4010, 1'b0, 32'h0, 0, 1'b0);
    chk(last_addr == BASE_B + 32'd16, "R3 idle base write applied", last_addr, BASE_B + 32'd16);
    chk(g_pa == 32'h0000_8010, "R11 result with new base", g_pa, 32'h0000_8010);
  endtask

  task automatic t_update();
    run_op(32'h0000_6000, 1'b1, 32'h5555_5001, 0, 1'b0);
    chk(last_we == 1'b1 && last_addr == BASE_B + 32'd24, "R9 write at entry address",
        last_addr, BASE_B + 32'd24);
    chk(last_wdata == 32'h5555_5007, "R9 ref and dirty set", last_wdata, 32'h5555_5007);
    chk(g_done && !g_fault && g_pte == 32'h5555_5007, "R9 update completes", g_pte, 32'h5555_5007);
    run_op(32'h0000_7000, 1'b1, 32'h0000_0000, 2, 1'b0);
    chk(last_wdata == 32'h0000_0006, "R9 absent entry written", last_wdata, 32'h6);
    chk(g_done && !g_fault, "R9 no fault on update", {30'b0, g_done, g_fault}, 32'h2);
    run_op(32'h0000_7000, 1'b0, 32'h0, 0, 1'b0);
    chk(g_fault && !g_done, "R7 written absent entry faults", {30'b0, g_done, g_fault}, 32'h1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    checks = 0; fails = 0; finished = 1'b0; hs_cnt = 0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    rst_n = 1'b0; cfg_base_we = 1'b0; cfg_base_wdata = '0;
    req_valid = 1'b0; req_vaddr = '0; req_upd = 1'b0; req_wdata = '0;
    mem_req_ready = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cfg_base_we = 1'b1; cfg_base_wdata = BASE_A;
    @(negedge clk); cfg_base_we = 1'b0;
    t_present();
    t_fault();
    t_stall();
    t_base();
    t_update();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule